// File: doc/BRIEF.md
# Inclusive Multi-Level Read-Fill Sequencer

This block serves one core read at a time through three direct-mapped cache levels and a main memory behind them. It looks up the closest level first and then the next ones in turn. When the line is found further out, it copies the line down one level per cycle until the closest level holds it. The returned word is always read from the closest level. While a level hands its line on, the sequencer holds a lock on that one line and shows it on a one-hot output. Locks are dropped innermost first, one level per cycle.

A line missing from every level is fetched from memory under a global bus lock. The bus lock is raised one cycle before the memory read starts. It is released only after every cache lock taken by the refill chain has been dropped. Each level is a tag/valid array with a fixed lookup latency, and a fill simply overwrites the indexed entry. A request is taken through a req/ready handshake when the block is idle. It completes with a one-cycle data-valid pulse that carries the selected 32-bit word of the 64-byte line.

Top module: `mlc_read_seq`

## Requirements
- R1: `ready_o` is high only when idle. A request is taken on a rising edge with `req_i && ready_o`. `ready_o` is low from the next cycle through the `rvalid_o` cycle and high again the cycle after. `req_i` asserted while busy starts no transaction and does not change the word returned.
- R2: A closest-level hit raises `rvalid_o` L1_LAT+3 cycles after the accepting edge (4 by default). It asserts only the closest-level lock, one-hot at bit (line address mod L1_LINES), with no other lock and no bus lock.
- R3: A middle-level hit locks that middle-level line, fills the closest level, then reads it. `rvalid_o` follows L1_LAT+L2_LAT+5 cycles after acceptance (10). A repeat of the same address then hits the closest level.
- R4: A far-level hit fills the middle level and then the closest level. `rvalid_o` follows L1_LAT+L2_LAT+L3_LAT+7 cycles after acceptance (22). A repeat then hits the closest level.
- R5: A miss in all levels raises `bus_lock_o` one cycle before `mem_rd_o`. `mem_rd_o` stays high for MEM_LAT cycles with `mem_addr_o` equal to the line address (`req_word_i[13:4]`). `mem_line_i` is taken on the last of those cycles. `rvalid_o` follows L1_LAT+L2_LAT+L3_LAT+MEM_LAT+9 cycles after acceptance (54).
- R6: `bus_lock_o` stays high until every cache lock has been dropped, and falls before `rvalid_o`.
- R7: Cache locks are released innermost first: the closest level, then the middle, then the far level, one per cycle.
- R8: Every lock vector is one-hot or zero at all times. No lock and no bus lock is high in the `rvalid_o` cycle or while idle.
- R9: `rdata_o` is bits [w*32 +: 32] of the 512-bit line, with w = `req_word_i[3:0]`. Memory word w of a line sits at those bits of `mem_line_i`.
- R10: Each level is direct-mapped with index = line address mod its line count. A fill overwrites that entry, and a line evicted from a closer level is still served by a further level that kept it.
- R11: After reset every level is empty, so the first access to any line misses, and all outputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request |
| req_word_i | input | 14 | Word address of the read (line address in [13:4], word in [3:0]) |
| ready_o | output | 1 | Idle, request can be taken |
| rvalid_o | output | 1 | One-cycle data-valid pulse |
| rdata_o | output | 32 | Returned word |
| lock_l1_o | output | 4 | Closest-level per-line lock, one-hot |
| lock_l2_o | output | 8 | Middle-level per-line lock, one-hot |
| lock_l3_o | output | 16 | Far-level per-line lock, one-hot |
| bus_lock_o | output | 1 | Global bus lock for a memory fetch |
| mem_rd_o | output | 1 | Memory read in progress |
| mem_addr_o | output | 10 | Line address sent to memory |
| mem_line_i | input | 512 | Line returned by memory |

## Verification
The bound checker watches, on every cycle, the properties of the handshake and the locks. These are the busy window of `ready_o`, one-hot lock vectors, the absence of locks at data-valid and in idle, the memory read sitting inside the bus lock, the bus lock outliving the cache locks, and the innermost-first release order. Only the directed scenarios can show the rest. That covers the exact latency of each hit depth and of a full miss, the word picked from the line, which line index each level locks, and that fills really leave the line in the closer levels. They also show that direct-mapped eviction sends a later access to the right level and that a request held high while busy is ignored.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int LINE_BYTES = 64;
  localparam int WORD_W     = 32;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int WORDS      = LINE_W / WORD_W;
  localparam int WOFF_W     = $clog2(WORDS);

  typedef logic [LINE_W-1:0] line_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE, S_BUS, S_MEMW, S_FILL, S_READ, S_REL, S_DONE
  } seq_state_e;
endpackage

// File: rtl/mlc_level.sv
module mlc_level
  import mlc_pkg::*;
#(
  parameter int LINES = 4,
  parameter int LA_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LA_W-1:0]  line_addr_i,
  input  logic             wr_en_i,
  input  line_t            wr_line_i,
  input  logic             lock_en_i,
  output logic             hit_o,
  output line_t            line_o,
  output logic [LINES-1:0] lock_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = LA_W - IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  line_t            data_q [LINES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  assign idx = line_addr_i[IDX_W-1:0];
  assign tag = line_addr_i[LA_W-1:IDX_W];

  assign hit_o  = valid_q[idx] && (tag_q[idx] == tag);
  assign line_o = data_q[idx];
  assign lock_o = lock_en_i ? (LINES'(1) << idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[idx] <= 1'b1;
  end

  // direct-mapped overwrite
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx]  <= tag;
      data_q[idx] <= wr_line_i;
    end
  end
endmodule

// File: rtl/mlc_ctrl.sv
module mlc_ctrl
  import mlc_pkg::*;
#(
  parameter int L1_LAT  = 1,
  parameter int L2_LAT  = 4,
  parameter int L3_LAT  = 10,
  parameter int MEM_LAT = 30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [2:0] hit_i,
  output logic       ready_o,
  output logic [2:0] lock_en_o,
  output logic       bus_lock_o,
  output logic       mem_rd_o,
  output logic [2:0] wr_en_o,
  output logic       cap_o,
  output logic       rvalid_o
);
  localparam int MAX_LAT = (MEM_LAT > L3_LAT) ? MEM_LAT : L3_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  seq_state_e       state_q, state_d;
  logic [1:0]       lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       held_q, held_d;
  logic             bus_q, bus_d;
  int               lim;

  always_comb begin
    case (lvl_q)
      2'd0:    lim = L1_LAT - 1;
      2'd1:    lim = L2_LAT - 1;
      default: lim = L3_LAT - 1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    cnt_d   = cnt_q;
    held_d  = held_q;
    bus_d   = bus_q;
    wr_en_o = '0;
    cap_o   = 1'b0;
    case (state_q)
      S_IDLE: if (req_i) begin
        state_d = S_PROBE;
        lvl_d   = 2'd0;
        cnt_d   = '0;
      end
      S_PROBE: begin
        if (int'(cnt_q) == lim) begin
          cnt_d = '0;
          if (hit_i[lvl_q]) begin
            held_d[lvl_q] = 1'b1;
            state_d = (lvl_q == 2'd0) ? S_READ : S_FILL;
          end else if (lvl_q == 2'd2) begin
            bus_d   = 1'b1;
            state_d = S_BUS;
          end else begin
            lvl_d = lvl_q + 2'd1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_BUS: begin
        cnt_d   = '0;
        state_d = S_MEMW;
      end
      S_MEMW: begin
        if (int'(cnt_q) == MEM_LAT - 1) begin
          wr_en_o[2] = 1'b1;
          held_d[2]  = 1'b1;
          lvl_d      = 2'd2;
          state_d    = S_FILL;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_FILL: begin
        // copy locked line one level closer, then lock that one
        wr_en_o[lvl_q - 2'd1] = 1'b1;
        held_d[lvl_q - 2'd1]  = 1'b1;
        lvl_d = lvl_q - 2'd1;
        if (lvl_q == 2'd1) state_d = S_READ;
      end
      S_READ: begin
        cap_o   = 1'b1;
        state_d = S_REL;
      end
      S_REL: begin
        if      (held_q[0]) held_d[0] = 1'b0;
        else if (held_q[1]) held_d[1] = 1'b0;
        else if (held_q[2]) held_d[2] = 1'b0;
        else if (bus_q)     bus_d     = 1'b0;
        else                state_d   = S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      lvl_q   <= '0;
      cnt_q   <= '0;
      held_q  <= '0;
      bus_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      cnt_q   <= cnt_d;
      held_q  <= held_d;
      bus_q   <= bus_d;
    end
  end

  assign ready_o    = (state_q == S_IDLE);
  assign rvalid_o   = (state_q == S_DONE);
  assign mem_rd_o   = (state_q == S_MEMW);
  assign lock_en_o  = held_q;
  assign bus_lock_o = bus_q;
endmodule

// File: rtl/mlc_read_seq.sv
module mlc_read_seq
  import mlc_pkg::*;
#(
  parameter int WADDR_W  = 14,
  parameter int L1_LINES = 4,
  parameter int L2_LINES = 8,
  parameter int L3_LINES = 16,
  parameter int L1_LAT   = 1,
  parameter int L2_LAT   = 4,
  parameter int L3_LAT   = 10,
  parameter int MEM_LAT  = 30
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [WADDR_W-1:0]      req_word_i,
  output logic                    ready_o,
  output logic                    rvalid_o,
  output logic [WORD_W-1:0]       rdata_o,
  output logic [L1_LINES-1:0]     lock_l1_o,
  output logic [L2_LINES-1:0]     lock_l2_o,
  output logic [L3_LINES-1:0]     lock_l3_o,
  output logic                    bus_lock_o,
  output logic                    mem_rd_o,
  output logic [WADDR_W-WOFF_W-1:0] mem_addr_o,
  input  logic [LINE_W-1:0]       mem_line_i
);
  localparam int LA_W = WADDR_W - WOFF_W;

  logic [WADDR_W-1:0] addr_q;
  logic [LA_W-1:0]    line_addr;
  logic [WOFF_W-1:0]  woff;
  logic [2:0]         hit, wr_en, lock_en;
  logic               cap;
  line_t              rd_line [3];
  line_t              wr_line [3];
  logic [WORD_W-1:0]  rdata_q;

  assign line_addr = addr_q[WADDR_W-1:WOFF_W];
  assign woff      = addr_q[WOFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (req_i && ready_o) addr_q <= req_word_i;
  end

  mlc_ctrl #(
    .L1_LAT (L1_LAT),
    .L2_LAT (L2_LAT),
    .L3_LAT (L3_LAT),
    .MEM_LAT(MEM_LAT)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .hit_i     (hit),
    .ready_o   (ready_o),
    .lock_en_o (lock_en),
    .bus_lock_o(bus_lock_o),
    .mem_rd_o  (mem_rd_o),
    .wr_en_o   (wr_en),
    .cap_o     (cap),
    .rvalid_o  (rvalid_o)
  );

  // each level is filled from the next one out; the far level from memory
  assign wr_line[0] = rd_line[1];
  assign wr_line[1] = rd_line[2];
  assign wr_line[2] = mem_line_i;

  for (genvar g = 0; g < 3; g++) begin : g_lvl
    localparam int LN = (g == 0) ? L1_LINES : (g == 1) ? L2_LINES : L3_LINES;
    logic [LN-1:0] lk;

    mlc_level #(
      .LINES(LN),
      .LA_W (LA_W)
    ) u_level (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .line_addr_i(line_addr),
      .wr_en_i    (wr_en[g]),
      .wr_line_i  (wr_line[g]),
      .lock_en_i  (lock_en[g]),
      .hit_o      (hit[g]),
      .line_o     (rd_line[g]),
      .lock_o     (lk)
    );

    if (g == 0) begin : g_o1
      assign lock_l1_o = lk;
    end else if (g == 1) begin : g_o2
      assign lock_l2_o = lk;
    end else begin : g_o3
      assign lock_l3_o = lk;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (cap) rdata_q <= rd_line[0][woff*WORD_W +: WORD_W];
  end

  assign rdata_o    = rdata_q;
  assign mem_addr_o = line_addr;
endmodule

// File: rtl/mlc_read_seq_chk.sv
module mlc_read_seq_chk #(
  parameter int L1_LINES = 4,
  parameter int L2_LINES = 8,
  parameter int L3_LINES = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                ready_o,
  input logic                rvalid_o,
  input logic [L1_LINES-1:0] lock_l1_o,
  input logic [L2_LINES-1:0] lock_l2_o,
  input logic [L3_LINES-1:0] lock_l3_o,
  input logic                bus_lock_o,
  input logic                mem_rd_o
);
  logic no_cache_lock;
  assign no_cache_lock = (lock_l1_o == '0) && (lock_l2_o == '0) && (lock_l3_o == '0);

  // R1
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  // R1
  ready_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> ready_o);

  // R8
  lock_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lock_l1_o) && $onehot0(lock_l2_o) && $onehot0(lock_l3_o));

  // R8
  valid_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (no_cache_lock && !bus_lock_o));

  // R8
  idle_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (no_cache_lock && !bus_lock_o && !mem_rd_o));

  // R5
  mem_in_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> bus_lock_o);

  // R5
  bus_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_rd_o) |-> $past(bus_lock_o));

  // R6
  bus_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_lock_o) |-> $past(no_cache_lock));

  // R7
  release_l2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|lock_l2_o) |-> (lock_l1_o == '0));

  // R7
  release_l3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|lock_l3_o) |-> ((lock_l1_o == '0) && (lock_l2_o == '0)));
endmodule

bind mlc_read_seq mlc_read_seq_chk #(
  .L1_LINES(L1_LINES),
  .L2_LINES(L2_LINES),
  .L3_LINES(L3_LINES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .ready_o   (ready_o),
  .rvalid_o  (rvalid_o),
  .lock_l1_o (lock_l1_o),
  .lock_l2_o (lock_l2_o),
  .lock_l3_o (lock_l3_o),
  .bus_lock_o(bus_lock_o),
  .mem_rd_o  (mem_rd_o)
);

// File: tb/mlc_read_seq_test.sv
module mlc_read_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int L1_LAT = 1, L2_LAT = 4, L3_LAT = 10, MEM_LAT = 30;
  localparam int EXP_L1  = L1_LAT + 3;
  localparam int EXP_L2  = L1_LAT + L2_LAT + 5;
  localparam int EXP_L3  = L1_LAT + L2_LAT + L3_LAT + 7;
  localparam int EXP_MEM = L1_LAT + L2_LAT + L3_LAT + MEM_LAT + 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic [13:0]  req_word = '0;
  logic         ready, rvalid, bus_lock, mem_rd;
  logic [31:0]  rdata;
  logic [3:0]   lock_l1;
  logic [7:0]   lock_l2;
  logic [15:0]  lock_l3;
  logic [9:0]   mem_addr;
  logic [511:0] mem_line;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mlc_read_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_word_i(req_word),
    .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .lock_l1_o(lock_l1), .lock_l2_o(lock_l2), .lock_l3_o(lock_l3),
    .bus_lock_o(bus_lock), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_line_i(mem_line)
  );

  function automatic logic [31:0] mem_word(logic [9:0] la, logic [3:0] w);
    return {w, 2'b10, la, 16'(int'(la) * 37 + int'(w) * 101)};
  endfunction

  // memory model: word w of a line at bits [w*32 +: 32]
  always_comb begin
    for (int w = 0; w < 16; w++) mem_line[w*32 +: 32] = mem_word(mem_addr, 4'(w));
  end

  localparam logic [9:0] LA_A = 10'h010, LA_B = 10'h014, LA_C = 10'h018;
  localparam logic [9:0] LA_D = 10'h025, LA_E = 10'h033;

  int          lat;
  logic [31:0] got;
  logic [3:0]  seen_l1;
  logic [7:0]  seen_l2;
  logic [15:0] seen_l3;
  bit          seen_bus, seen_mem, order_bad, ready_bad, locked_at_valid;
  logic [9:0]  mem_la;
  int          last_l1, last_l2, last_l3, last_bus;

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic run(input logic [13:0] wa, input bit hold, input logic [13:0] other);
    bit prev_bus, prev_mem;
    @(negedge clk);
    req = 1'b1;
    req_word = wa;
    @(posedge clk);
    @(negedge clk);
    if (hold) req_word = other;
    else req = 1'b0;
    lat = 0; seen_l1 = '0; seen_l2 = '0; seen_l3 = '0;
    seen_bus = 0; seen_mem = 0; order_bad = 0; ready_bad = 0; mem_la = '0;
    last_l1 = -1; last_l2 = -1; last_l3 = -1; last_bus = -1;
    prev_bus = 0; prev_mem = 0;
    while (!rvalid && lat < 400) begin
      if (ready) ready_bad = 1;
      seen_l1 |= lock_l1; seen_l2 |= lock_l2; seen_l3 |= lock_l3;
      if (|lock_l1) last_l1 = lat;
      if (|lock_l2) last_l2 = lat;
      if (|lock_l3) last_l3 = lat;
      if (bus_lock) begin last_bus = lat; seen_bus = 1; end
      if (mem_rd) begin
        seen_mem = 1;
        mem_la = mem_addr;
        if (!prev_mem && !prev_bus) order_bad = 1;
      end
      prev_bus = bus_lock;
      prev_mem = mem_rd;
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    got = rdata;
    locked_at_valid = (|lock_l1) || (|lock_l2) || (|lock_l3) || bus_lock;
    if (hold) req = 1'b0;
  endtask

  task automatic t_reset;
    chk(ready == 1'b1, "R11", "ready after reset", ready, 1);
    chk(rvalid == 1'b0, "R11", "rvalid after reset", rvalid, 0);
    chk({lock_l1, lock_l2, lock_l3} == '0, "R11", "locks after reset",
        {lock_l1, lock_l2, lock_l3}, 0);
    chk(!bus_lock && !mem_rd, "R11", "bus/mem after reset", {bus_lock, mem_rd}, 0);
  endtask

  task automatic t_cold_miss;
    run({LA_A, 4'd3}, 0, '0);
    chk(lat == EXP_MEM, "R5", "miss latency", lat, EXP_MEM);
    chk(got == mem_word(LA_A, 4'd3), "R9", "miss word 3", got, mem_word(LA_A, 4'd3));
    chk(seen_bus && seen_mem && !order_bad, "R5", "bus lock before mem read",
        {seen_bus, seen_mem, order_bad}, 3'b110);
    chk(mem_la == LA_A, "R5", "mem line address", mem_la, LA_A);
    chk(seen_l3 == 16'(1) << (LA_A % 16), "R10", "far lock index", seen_l3, 16'(1) << (LA_A % 16));
    chk(seen_l2 == 8'(1) << (LA_A % 8), "R10", "mid lock index", seen_l2, 8'(1) << (LA_A % 8));
    chk(last_l1 < last_l2 && last_l2 < last_l3, "R7", "release order l1<l2<l3",
        {last_l1, last_l2, last_l3}, 0);
    chk(last_l3 < last_bus, "R6", "bus lock outlives cache locks", last_bus, last_l3 + 1);
    chk(!locked_at_valid, "R8", "no lock at data-valid", locked_at_valid, 0);
    chk(!ready_bad, "R1", "ready low while busy", ready_bad, 0);
  endtask

  task automatic t_l1_hit;
    run({LA_A, 4'd15}, 0, '0);
    chk(lat == EXP_L1, "R2", "closest hit latency", lat, EXP_L1);
    chk(got == mem_word(LA_A, 4'd15), "R9", "word 15", got, mem_word(LA_A, 4'd15));
    chk(seen_l1 == 4'(1) << (LA_A % 4), "R2", "closest lock index", seen_l1, 4'(1) << (LA_A % 4));
    chk(seen_l2 == '0 && seen_l3 == '0 && !seen_bus, "R2", "no other lock",
        {seen_l2, seen_l3, 7'(seen_bus)}, 0);
    run({LA_A, 4'd0}, 0, '0);
    chk(got == mem_word(LA_A, 4'd0), "R9", "word 0", got, mem_word(LA_A, 4'd0));
  endtask

  task automatic t_l2_hit;
    run({LA_B, 4'd5}, 0, '0);
    chk(lat == EXP_MEM, "R10", "conflict line misses", lat, EXP_MEM);
    run({LA_A, 4'd9}, 0, '0);
    chk(lat == EXP_L2, "R3", "evicted line served by middle level", lat, EXP_L2);
    chk(got == mem_word(LA_A, 4'd9), "R3", "middle hit data", got, mem_word(LA_A, 4'd9));
    chk(seen_l2 == 8'(1) << (LA_A % 8) && seen_l3 == '0 && !seen_mem, "R3",
        "middle lock only", seen_l2, 8'(1) << (LA_A % 8));
    run({LA_A, 4'd9}, 0, '0);
    chk(lat == EXP_L1, "R3", "closest level filled", lat, EXP_L1);
  endtask

  task automatic t_l3_hit;
    run({LA_C, 4'd2}, 0, '0);
    chk(lat == EXP_MEM, "R10", "second conflict misses", lat, EXP_MEM);
    run({LA_A, 4'd1}, 0, '0);
    chk(lat == EXP_L3, "R4", "far hit latency", lat, EXP_L3);
    chk(got == mem_word(LA_A, 4'd1), "R4", "far hit data", got, mem_word(LA_A, 4'd1));
    chk(seen_l3 == 16'(1) << (LA_A % 16) && !seen_mem, "R4", "far lock only",
        seen_l3, 16'(1) << (LA_A % 16));
    run({LA_A, 4'd1}, 0, '0);
    chk(lat == EXP_L1, "R4", "closest level refilled", lat, EXP_L1);
    run({LA_B, 4'd6}, 0, '0);
    chk(lat == EXP_L2, "R10", "untouched middle entry kept", lat, EXP_L2);
    chk(got == mem_word(LA_B, 4'd6), "R10", "kept entry data", got, mem_word(LA_B, 4'd6));
  endtask

  task automatic t_busy_req;
    bit extra;
    run({LA_D, 4'd4}, 1, {LA_E, 4'd8});
    chk(lat == EXP_MEM, "R1", "held request latency", lat, EXP_MEM);
    chk(got == mem_word(LA_D, 4'd4), "R1", "busy request ignored", got, mem_word(LA_D, 4'd4));
    chk(!ready_bad, "R1", "ready low while busy", ready_bad, 0);
    extra = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rvalid || !ready) extra = 1;
    end
    chk(!extra, "R1", "no extra transaction", extra, 0);
    run({LA_E, 4'd8}, 0, '0);
    chk(lat == EXP_MEM, "R1", "ignored address never fetched", lat, EXP_MEM);
    chk(got == mem_word(LA_E, 4'd8), "R9", "word 8", got, mem_word(LA_E, 4'd8));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_miss();
    t_l1_hit();
    t_l2_hit();
    t_l3_hit();
    t_busy_req();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule